// File: doc/BRIEF.md
# Set-Associative Translation Cache with Access Rights

This block caches translations from 20-bit virtual page numbers to physical page numbers. Each entry also carries read, write and execute rights for its page. A lookup presents a virtual page number together with an access kind. In the same cycle the block answers in one of three ways: a hit that delivers the physical page number, a rights fault when the page is present but does not allow that access, or a miss.

On a miss the block raises a walk request that carries the missing page number. When the table walker has the translation, it returns it on the fill port. The block places it in the indexed set: into the way that already holds that page, or else into the lowest invalid way, or else into the least recently used way. Recency is tracked with true LRU among the four ways of each set. A single-cycle flush empties the whole cache, for use when the translation base changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses. The recency ranks of each set start distinct, with way 0 as most recent and way 3 as least recent.
- R2: A lookup whose page matches a valid entry, with the needed right present, raises lk_hit in the same cycle and drives that entry's physical page number on lk_ppn. The set index is lk_vpn[3:0] and the tag is lk_vpn[19:4].
- R3: Access kinds are encoded as 00 read (needs perm bit 0), 01 write (needs perm bit 1), 10 execute (needs perm bit 2), and 11, which no page allows. A matching entry without the needed right raises lk_fault instead of lk_hit, and lk_ppn reads zero.
- R4: A lookup with no matching valid entry raises lk_miss and walk_req, with walk_vpn equal to lk_vpn, in the same cycle. While lk_valid is high exactly one of hit, fault and miss is high. While lk_valid is low all three are low, and lk_ppn is zero whenever lk_hit is low.
- R5: A fill is written at the clock edge and is visible to lookups from the next cycle. A fill for a page already cached overwrites that same way, so no page is ever held twice.
- R6: A fill of a new page goes to the lowest-numbered invalid way of its set. If every way of the set is valid, it goes to the least recently used way.
- R7: A hit, but not a fault, makes its way the most recent of the set at the next edge. A fill makes the filled way the most recent.
- R8: Flush invalidates every entry in one cycle. A fill in the same cycle as a flush is dropped.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill. When a hit and a fill touch the same set in one cycle, the hit's recency update is applied first. The fill then picks its way from the updated order and ends as the most recent way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_acc | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 none) |
| lk_hit | output | 1 | Translation found and allowed |
| lk_fault | output | 1 | Translation found, right missing |
| lk_miss | output | 1 | No translation cached |
| lk_ppn | output | 20 | Physical page number on hit, zero otherwise |
| walk_req | output | 1 | Request to the table walker |
| walk_vpn | output | 20 | Page number the walker must resolve |
| fill_valid | input | 1 | Install a translation at this edge |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_perm | input | 3 | Rights of the fill: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate all entries |

## Verification
A lookup and a fill may land in the same cycle, and in the same set, so their recency updates have to be combined. The random phase confines page numbers to two sets and a handful of tags, so fills and hits to the same set collide often. Directed cases also place a hit on one way alongside a fill to the same set. The outcome is judged by which page a later fill evicts, compared with a bench model that applies the hit update first and then the fill. Flush and fill in the same cycle are provoked as well, and a lookup of the filled page in the next cycle must miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  function automatic logic perm_allows(logic [PERM_W-1:0] perm, acc_e acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[PERM_RD];
      ACC_WRITE: ok = perm[PERM_WR];
      ACC_EXEC:  ok = perm[PERM_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_match,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  output logic              wr_set_valid,
  output logic              wr_set_match
);

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [PPN_W-1:0]  ppn_mem  [SETS];
  logic [PERM_W-1:0] perm_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      ppn_mem[wr_idx]  <= wr_ppn;
      perm_mem[wr_idx] <= wr_perm;
    end
  end

  assign lk_match     = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_ppn       = ppn_mem[lk_idx];
  assign lk_perm      = perm_mem[lk_idx];
  assign wr_set_valid = vld_q[wr_idx];
  assign wr_set_match = vld_q[wr_idx] && (tag_mem[wr_idx] == wr_tag);

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0)); // R8

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld_q[$past(wr_idx)]); // R5

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ta_en,
  input  logic [IDX_W-1:0] ta_idx,
  input  logic [WAY_W-1:0] ta_way,
  input  logic             tb_en,
  input  logic [IDX_W-1:0] tb_idx,
  input  logic [WAY_W-1:0] tb_way,
  output logic [WAY_W-1:0] victim_way
);

  typedef logic [WAYS-1:0][WAY_W-1:0] ranks_t;

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  ranks_t rank_q [SETS];
  ranks_t ranks_a;
  ranks_t base_b;
  ranks_t ranks_b;
  logic [WAYS-1:0] old_mask;

  function automatic ranks_t touch(ranks_t r, logic [WAY_W-1:0] w);
    ranks_t n;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == w)  n[i] = '0;
      else if (r[i] < r[w]) n[i] = r[i] + 1'b1;
      else                 n[i] = r[i];
    end
    return n;
  endfunction

  always_comb begin
    ranks_a = touch(rank_q[ta_idx], ta_way);
    base_b  = (ta_en && (ta_idx == tb_idx)) ? ranks_a : rank_q[tb_idx];
    ranks_b = touch(base_b, tb_way);
    victim_way = '0;
    old_mask   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (base_b[i] == OLDEST) begin
        victim_way  = WAY_W'(i);
        old_mask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int i = 0; i < WAYS; i++) begin
          rank_q[s][i] <= WAY_W'(i);
        end
      end
    end else begin
      if (ta_en) rank_q[ta_idx] <= ranks_a;
      if (tb_en) rank_q[tb_idx] <= ranks_b;
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $countones(old_mask) == 1); // R7

  AST_FILL_NEWEST: assert property (@(posedge clk) disable iff (rst)
    tb_en |=> (rank_q[$past(tb_idx)][$past(tb_way)] == '0)); // R7

  AST_HIT_SECOND: assert property (@(posedge clk) disable iff (rst)
    (ta_en && tb_en && (ta_idx == tb_idx) && (ta_way != tb_way))
      |=> (rank_q[$past(ta_idx)][$past(ta_way)] == WAY_W'(1))); // R9

endmodule

// File: rtl/tlb_fill_pick.sv
module tlb_fill_pick #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_match,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] pick_way
);

  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] hit_way;

  always_comb begin
    free_way = '0;
    hit_way  = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_valid[i]) free_way = WAY_W'(i);
      if (set_match[i])  hit_way  = WAY_W'(i);
    end
    if (|set_match)       pick_way = hit_way;
    else if (!(&set_valid)) pick_way = free_way;
    else                  pick_way = lru_way;
  end

  always_comb begin
    AST_PICK_FREE: assert ((|set_match) || (&set_valid) || !set_valid[pick_way]); // R6
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WAYS    = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush
);

  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;
  logic             fill_en;

  logic [WAYS-1:0]   way_match;
  logic [PPN_W-1:0]  way_ppn  [WAYS];
  logic [PERM_W-1:0] way_perm [WAYS];
  logic [WAYS-1:0]   way_fvld;
  logic [WAYS-1:0]   way_fmatch;

  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  lru_way;
  logic [WAY_W-1:0]  pick_way;
  logic [PPN_W-1:0]  sel_ppn;
  logic [PERM_W-1:0] sel_perm;
  logic              present;
  logic              allowed;

  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fl_idx  = fill_vpn[IDX_W-1:0];
  assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
  assign fill_en = fill_valid && !flush;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    tlb_way #(
      .SETS  (SETS),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W)
    ) way_i (
      .clk          (clk),
      .rst          (rst),
      .flush        (flush),
      .lk_idx       (lk_idx),
      .lk_tag       (lk_tag),
      .lk_match     (way_match[g]),
      .lk_ppn       (way_ppn[g]),
      .lk_perm      (way_perm[g]),
      .wr_en        (fill_en && (pick_way == WAY_W'(g))),
      .wr_idx       (fl_idx),
      .wr_tag       (fl_tag),
      .wr_ppn       (fill_ppn),
      .wr_perm      (fill_perm),
      .wr_set_valid (way_fvld[g]),
      .wr_set_match (way_fmatch[g])
    );
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) hit_way = WAY_W'(w);
    end
    sel_ppn  = way_ppn[hit_way];
    sel_perm = way_perm[hit_way];
  end

  assign present  = |way_match;
  assign allowed  = perm_allows(sel_perm, acc_e'(lk_acc));
  assign lk_hit   = lk_valid && present && allowed;
  assign lk_fault = lk_valid && present && !allowed;
  assign lk_miss  = lk_valid && !present;
  assign lk_ppn   = lk_hit ? sel_ppn : '0;
  assign walk_req = lk_miss;
  assign walk_vpn = lk_vpn;

  tlb_lru #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .IDX_W (IDX_W),
    .WAY_W (WAY_W)
  ) lru_i (
    .clk        (clk),
    .rst        (rst),
    .ta_en      (lk_hit),
    .ta_idx     (lk_idx),
    .ta_way     (hit_way),
    .tb_en      (fill_en),
    .tb_idx     (fl_idx),
    .tb_way     (pick_way),
    .victim_way (lru_way)
  );

  tlb_fill_pick #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
  ) pick_i (
    .set_valid (way_fvld),
    .set_match (way_fmatch),
    .lru_way   (lru_way),
    .pick_way  (pick_way)
  );

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ($countones({lk_hit, lk_fault, lk_miss}) == 1)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !(lk_hit || lk_fault || lk_miss || walk_req)); // R4

  AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
    $countones(way_match) <= 1); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> !present); // R8

endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 16;
  localparam int NWAYS = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [19:0] lk_vpn;
  logic [1:0]  lk_acc;
  logic        lk_hit, lk_fault, lk_miss, walk_req;
  logic [19:0] lk_ppn, walk_vpn;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_ppn;
  logic [2:0]  fill_perm;
  logic        flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit        m_vld  [NSETS][NWAYS];
  bit [15:0] m_tag  [NSETS][NWAYS];
  bit [19:0] m_ppn  [NSETS][NWAYS];
  bit [2:0]  m_perm [NSETS][NWAYS];
  int        m_rank [NSETS][NWAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_miss(lk_miss), .lk_ppn(lk_ppn),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush(flush)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_allows(bit [2:0] p, bit [1:0] a);
    return (a == 2'b11) ? 1'b0 : p[a];
  endfunction

  task automatic m_touch(int s, int w);
    int r = m_rank[s][w];
    for (int i = 0; i < NWAYS; i++) begin
      if (i == w) m_rank[s][i] = 0;
      else if (m_rank[s][i] < r) m_rank[s][i]++;
    end
  endtask

  task automatic m_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_vld[s][w] = 0;
        m_rank[s][w] = w;
      end
  endtask

  // One cycle: drive at negedge, check outputs, update model after posedge.
  task automatic step(string req, bit lv, bit [19:0] vpn, bit [1:0] acc,
                      bit fv, bit [19:0] fvpn, bit [19:0] fppn, bit [2:0] fperm, bit fl);
    int idx, hw, fidx, way;
    bit e_hit, e_fault, e_miss;
    @(negedge clk);
    lk_valid = lv; lk_vpn = vpn; lk_acc = acc;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm; flush = fl;
    #1;
    idx = vpn[3:0];
    hw = -1;
    for (int w = 0; w < NWAYS; w++)
      if (m_vld[idx][w] && m_tag[idx][w] == vpn[19:4]) hw = w;
    e_hit   = lv && hw >= 0 && m_allows(m_perm[idx][hw], acc);
    e_fault = lv && hw >= 0 && !m_allows(m_perm[idx][hw], acc);
    e_miss  = lv && hw < 0;
    chk({req, "/R2"}, "lk_hit", 32'(lk_hit), 32'(e_hit));
    chk({req, "/R3"}, "lk_fault", 32'(lk_fault), 32'(e_fault));
    chk({req, "/R4"}, "lk_miss", 32'(lk_miss), 32'(e_miss));
    chk({req, "/R4"}, "walk_req", 32'(walk_req), 32'(e_miss));
    chk({req, "/R2"}, "lk_ppn", 32'(lk_ppn), e_hit ? 32'(m_ppn[idx][hw]) : 32'd0);
    if (e_miss) chk({req, "/R4"}, "walk_vpn", 32'(walk_vpn), 32'(vpn));
    @(posedge clk);
    if (e_hit) m_touch(idx, hw);
    if (fl) begin
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < NWAYS; w++) m_vld[s][w] = 0;
    end else if (fv) begin
      fidx = fvpn[3:0];
      way = -1;
      for (int w = 0; w < NWAYS; w++)
        if (m_vld[fidx][w] && m_tag[fidx][w] == fvpn[19:4]) way = w;
      if (way < 0)
        for (int w = NWAYS - 1; w >= 0; w--) if (!m_vld[fidx][w]) way = w;
      if (way < 0)
        for (int w = 0; w < NWAYS; w++) if (m_rank[fidx][w] == NWAYS - 1) way = w;
      m_vld[fidx][way] = 1;
      m_tag[fidx][way] = fvpn[19:4];
      m_ppn[fidx][way] = fppn;
      m_perm[fidx][way] = fperm;
      m_touch(fidx, way);
    end
  endtask

  task automatic look(string req, bit [19:0] vpn, bit [1:0] acc);
    step(req, 1, vpn, acc, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string req, bit [19:0] vpn, bit [19:0] ppn, bit [2:0] perm);
    step(req, 0, 0, 0, 1, vpn, ppn, perm, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; lk_valid = 0; lk_vpn = 0; lk_acc = 0;
    fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_perm = 0; flush = 0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: empty after reset
    look("R1", 20'h00000, 2'b00);
    look("R1", 20'h12345, 2'b10);
    step("R4", 0, 20'h00005, 0, 0, 0, 0, 0, 0);

    // R6 R7: fill four ways of set 5, then evict the least recent
    for (int t = 1; t <= 4; t++) fill("R6", {16'(t), 4'h5}, 20'(32'hA000 + t), 3'b111);
    for (int t = 1; t <= 4; t++) look("R2", {16'(t), 4'h5}, 2'b00);
    fill("R6", {16'd5, 4'h5}, 20'hA005, 3'b111);
    look("R7", {16'd1, 4'h5}, 2'b00);
    look("R7", {16'd3, 4'h5}, 2'b00);
    fill("R7", {16'd6, 4'h5}, 20'hA006, 3'b111);
    look("R7", {16'd2, 4'h5}, 2'b00);
    look("R7", {16'd3, 4'h5}, 2'b00);

    // R3: rights
    fill("R3", {16'h77, 4'h9}, 20'hBEEF1, 3'b001);
    look("R3", {16'h77, 4'h9}, 2'b00);
    look("R3", {16'h77, 4'h9}, 2'b01);
    look("R3", {16'h77, 4'h9}, 2'b10);
    look("R3", {16'h77, 4'h9}, 2'b11);
    fill("R5", {16'h77, 4'h9}, 20'hC0DE2, 3'b110);
    look("R5", {16'h77, 4'h9}, 2'b01);
    look("R5", {16'h77, 4'h9}, 2'b00);

    // R9: same-cycle lookup and fill, and hit plus fill in one set
    step("R9", 1, {16'h88, 4'h9}, 2'b10, 1, {16'h88, 4'h9}, 20'h00ABC, 3'b100, 0);
    look("R9", {16'h88, 4'h9}, 2'b10);
    step("R9", 1, {16'd6, 4'h5}, 2'b00, 1, {16'd9, 4'h5}, 20'hA009, 3'b111, 0);
    look("R9", {16'd6, 4'h5}, 2'b00);
    fill("R9", {16'd10, 4'h5}, 20'hA00A, 3'b111);
    look("R9", {16'd6, 4'h5}, 2'b00);

    // R8: flush, and flush with fill
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    look("R8", {16'd6, 4'h5}, 2'b00);
    look("R8", {16'h77, 4'h9}, 2'b01);
    step("R8", 0, 0, 0, 1, {16'h1, 4'h3}, 20'h11111, 3'b111, 1);
    look("R8", {16'h1, 4'h3}, 2'b00);

    // Random traffic in two sets and six tags
    for (int n = 0; n < 4000; n++) begin
      bit [19:0] v = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 1))};
      bit [19:0] f = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 1))};
      step("R5", 1'($urandom_range(0, 3) != 0), v, 2'($urandom),
           1'($urandom_range(0, 2) == 0), f, 20'($urandom), 3'($urandom),
           1'($urandom_range(0, 60) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule